// File: doc/BRIEF.md
# Bank Conflict Slot Scheduler

This block decides how many cycles one instruction needs to gather its memory items, and hands out those accesses cycle by cycle. An instruction may need up to three accesses: an instruction fetch, which is needed only when the instruction cache misses; a data-bus access; and a program-bus access. Each access carries the number of the memory bank it targets. Two accesses that target the same bank cannot share a cycle, so the block spreads them over successive cycles.

A start pulse, given while the block is idle, captures the three request descriptors. From the next cycle the block raises busy and drives one grant per access in each cycle. It pulses done in the last cycle that holds a grant. It also reports the total cycle count for the instruction as soon as it is busy. Grants follow a fixed order: the fetch first, then the data-bus access, then the program-bus access. A lower-ranked access is held back only when a higher-ranked access that is granted in the same cycle uses its bank. The cycle count therefore equals the size of the largest group of needed accesses that share one bank. An instruction with no accesses still takes one cycle.

Top module: `bank_slot_sched`

## Requirements
- R1: After reset, busy_o, done_o and all three grants are 0 and cycles_o is 0.
- R2: A start_i sampled while idle is captured. busy_o is 1 from the next cycle until done, and cycles_o shows that instruction's cycle count from the first busy cycle until the next accepted start.
- R3: With a cache miss and all three accesses on distinct banks, all three grants and done_o assert together in the single busy cycle, and cycles_o is 1.
- R4: On a cache hit (fetch_need_i = 0), grant_fetch_o never asserts. Two data accesses on distinct banks both complete in one cycle.
- R5: When exactly two of the needed accesses share a bank (data against data, or fetch against data), the instruction takes 2 cycles.
- R6: When the fetch and both data accesses target the same bank, the instruction takes 3 cycles, with one grant per cycle.
- R7: Among the accesses that share a bank, grants go in the order fetch, data-bus, program-bus. An access on a free bank is granted in the first cycle.
- R8: No two grants in one cycle target the same bank, and each needed access is granted in exactly one cycle.
- R9: done_o asserts in the last granted cycle and busy_o is 0 in the following cycle. A start_i in that following cycle is accepted.
- R10: A start_i raised while busy_o is 1 (the done cycle included) is ignored. It changes neither the grants nor cycles_o.
- R11: An instruction with no accesses (cache hit and no data needs) takes one busy cycle with done_o and no grants.
- R12: An instruction with one data access takes 1 cycle when that access and a needed fetch use different banks. It takes 2 cycles when they use the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; captures the descriptors when idle |
| fetch_need_i | input | 1 | Instruction fetch needed (cache miss) |
| fetch_bank_i | input | BANK_W | Bank holding the instruction |
| dbus_need_i | input | 1 | Data-bus access needed |
| dbus_bank_i | input | BANK_W | Bank of the data-bus access |
| pbus_need_i | input | 1 | Program-bus access needed |
| pbus_bank_i | input | BANK_W | Bank of the program-bus access |
| busy_o | output | 1 | Instruction in progress |
| grant_fetch_o | output | 1 | Fetch granted this cycle |
| grant_dbus_o | output | 1 | Data-bus access granted this cycle |
| grant_pbus_o | output | 1 | Program-bus access granted this cycle |
| done_o | output | 1 | Last granted cycle of the instruction |
| cycles_o | output | CNT_W | Cycle count of the current or last instruction |

## Verification
The assertions assume that the descriptor inputs matter only in the cycle when start_i is sampled while idle. They also assume that start_i, when raised while busy, has no effect. The stimulus drives every input on the falling edge and holds the descriptors steady only around the capture edge. It deliberately pulses start_i with other descriptors in the middle of an instruction, so the assertion that cycles_o stays stable while busy is exercised under a start that must be refused. Every scenario sets bank numbers so that the expected grant pattern of each cycle is fixed in advance by the bank sharing alone.

// File: rtl/bank_slot_pkg.sv
// Shared constants and types for the bank conflict slot scheduler.
// Access slot order is also grant priority: fetch, data bus, program bus.
package bank_slot_pkg;
    localparam int NUM_ACC   = 3;
    localparam int ACC_FETCH = 0;
    localparam int ACC_DBUS  = 1;
    localparam int ACC_PBUS  = 2;
    localparam int CNT_W     = $clog2(NUM_ACC + 1);

    typedef logic [NUM_ACC-1:0] acc_vec_t;
endpackage

// File: rtl/slot_count_pred.sv
// Predicts the cycle count of one instruction: the size of the largest
// group of needed accesses that share one bank, at least one.
// Assumes the need and bank vectors are valid for the instruction being captured.
module slot_count_pred
    import bank_slot_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  acc_vec_t                          need,
    input  logic [NUM_ACC-1:0][BANK_W-1:0]    bank,
    output logic [CNT_W-1:0]                  cnt
);
    // Largest same-bank group among needed accesses, with a floor of one.
    always_comb begin
        logic [CNT_W-1:0] best;
        logic [CNT_W-1:0] grp;
        best = CNT_W'(1);
        for (int i = 0; i < NUM_ACC; i++) begin
            grp = '0;
            for (int j = 0; j < NUM_ACC; j++) begin
                if (need[i] && need[j] && bank[j] == bank[i]) begin
                    grp = grp + CNT_W'(1);
                end
            end
            if (grp > best) begin
                best = grp;
            end
        end
        cnt = best;
    end
endmodule

// File: rtl/slot_arbiter.sv
// Fixed-priority, bank-aware grant logic for one cycle. A pending access
// is granted unless a higher-priority access granted this cycle uses its bank.
// Assumes index 0 has the highest priority.
module slot_arbiter
    import bank_slot_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  acc_vec_t                          pend,
    input  logic [NUM_ACC-1:0][BANK_W-1:0]    bank,
    output acc_vec_t                          grant
);
    // Walk the slots in priority order, blocking on banks already taken.
    always_comb begin
        grant = '0;
        for (int i = 0; i < NUM_ACC; i++) begin
            grant[i] = pend[i];
            for (int j = 0; j < NUM_ACC; j++) begin
                if (j < i && grant[j] && bank[j] == bank[i]) begin
                    grant[i] = 1'b0;
                end
            end
        end
    end

    AST_NO_BANK_CLASH_FD: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[ACC_FETCH] && grant[ACC_DBUS]) |-> (bank[ACC_FETCH] != bank[ACC_DBUS])); // R8
    AST_NO_BANK_CLASH_FP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[ACC_FETCH] && grant[ACC_PBUS]) |-> (bank[ACC_FETCH] != bank[ACC_PBUS])); // R8
    AST_NO_BANK_CLASH_DP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[ACC_DBUS] && grant[ACC_PBUS]) |-> (bank[ACC_DBUS] != bank[ACC_PBUS])); // R8
    AST_GRANT_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~pend) == '0); // R8
endmodule

// File: rtl/slot_tracker.sv
// Holds the state of one instruction: which accesses are still pending,
// their banks and the predicted cycle count. Accepts a start only when idle.
// Assumes grant comes from slot_arbiter working on pend_o and bank_o.
module slot_tracker
    import bank_slot_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  acc_vec_t                          need,
    input  logic [NUM_ACC-1:0][BANK_W-1:0]    bank_in,
    input  logic [CNT_W-1:0]                  cnt_pred,
    input  acc_vec_t                          grant,
    output logic                              active_o,
    output acc_vec_t                          pend_o,
    output logic [NUM_ACC-1:0][BANK_W-1:0]    bank_o,
    output logic [CNT_W-1:0]                  cycles_o,
    output logic                              done_o
);
    logic             accept;
    logic [CNT_W-1:0] elapsed_q;

    assign accept = start && !active_o;
    assign done_o = active_o && ((pend_o & ~grant) == '0);

    // Capture a new instruction or retire granted accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            pend_o   <= '0;
            bank_o   <= '0;
            cycles_o <= '0;
        end else if (accept) begin
            active_o <= 1'b1;
            pend_o   <= need;
            bank_o   <= bank_in;
            cycles_o <= cnt_pred;
        end else if (active_o) begin
            pend_o <= pend_o & ~grant;
            if (done_o) begin
                active_o <= 1'b0;
            end
        end
    end

    // Cycle counter of the running instruction, for the count check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (accept) begin
            elapsed_q <= CNT_W'(1);
        end else if (active_o && !done_o) begin
            elapsed_q <= elapsed_q + CNT_W'(1);
        end
    end

    AST_CYCLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (elapsed_q == cycles_o)); // R5
    AST_DONE_DROPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !active_o); // R9
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start && active_o) |=> $stable(cycles_o)); // R10
    AST_NO_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |=> ((grant & $past(grant)) == '0)); // R8
endmodule

// File: rtl/bank_slot_sched.sv
// Top of the bank conflict slot scheduler. Captures one instruction's
// access descriptors on an idle start, then grants the accesses over as
// many cycles as the bank sharing demands, pulsing done in the last one.
// Assumes the fetch need is already cleared by the caller on a cache hit.
module bank_slot_sched
    import bank_slot_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              fetch_need_i,
    input  logic [BANK_W-1:0] fetch_bank_i,
    input  logic              dbus_need_i,
    input  logic [BANK_W-1:0] dbus_bank_i,
    input  logic              pbus_need_i,
    input  logic [BANK_W-1:0] pbus_bank_i,
    output logic              busy_o,
    output logic              grant_fetch_o,
    output logic              grant_dbus_o,
    output logic              grant_pbus_o,
    output logic              done_o,
    output logic [CNT_W-1:0]  cycles_o
);
    acc_vec_t                        need_in;
    logic [NUM_ACC-1:0][BANK_W-1:0]  bank_in;
    logic [CNT_W-1:0]                cnt_pred;
    acc_vec_t                        pend;
    logic [NUM_ACC-1:0][BANK_W-1:0]  bank_q;
    acc_vec_t                        grant;
    logic                            active;

    // Pack the descriptors into priority-ordered slots.
    always_comb begin
        need_in            = '0;
        need_in[ACC_FETCH] = fetch_need_i;
        need_in[ACC_DBUS]  = dbus_need_i;
        need_in[ACC_PBUS]  = pbus_need_i;
        bank_in            = '0;
        bank_in[ACC_FETCH] = fetch_bank_i;
        bank_in[ACC_DBUS]  = dbus_bank_i;
        bank_in[ACC_PBUS]  = pbus_bank_i;
    end

    slot_count_pred #(.BANK_W(BANK_W)) pred_i (
        .need (need_in),
        .bank (bank_in),
        .cnt  (cnt_pred)
    );

    slot_tracker #(.BANK_W(BANK_W)) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .need     (need_in),
        .bank_in  (bank_in),
        .cnt_pred (cnt_pred),
        .grant    (grant),
        .active_o (active),
        .pend_o   (pend),
        .bank_o   (bank_q),
        .cycles_o (cycles_o),
        .done_o   (done_o)
    );

    slot_arbiter #(.BANK_W(BANK_W)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend),
        .bank  (bank_q),
        .grant (grant)
    );

    assign busy_o        = active;
    assign grant_fetch_o = grant[ACC_FETCH];
    assign grant_dbus_o  = grant[ACC_DBUS];
    assign grant_pbus_o  = grant[ACC_PBUS];

    AST_GRANT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_fetch_o || grant_dbus_o || grant_pbus_o) |-> busy_o); // R2
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_FETCH_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_dbus_o && busy_o) |-> !(pend[ACC_FETCH] && !grant_fetch_o
                                        && bank_q[ACC_FETCH] == bank_q[ACC_DBUS])); // R7
endmodule

// File: tb/bank_slot_sched_tb_top.sv
// Directed bench for the bank conflict slot scheduler.
module bank_slot_sched_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          fetch_need_i = 1'b0, dbus_need_i = 1'b0, pbus_need_i = 1'b0;
    logic [BW-1:0] fetch_bank_i = '0, dbus_bank_i = '0, pbus_bank_i = '0;
    logic          busy_o, grant_fetch_o, grant_dbus_o, grant_pbus_o, done_o;
    logic [1:0]    cycles_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bank_slot_sched #(.BANK_W(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .fetch_need_i(fetch_need_i), .fetch_bank_i(fetch_bank_i),
        .dbus_need_i(dbus_need_i), .dbus_bank_i(dbus_bank_i),
        .pbus_need_i(pbus_need_i), .pbus_bank_i(pbus_bank_i),
        .busy_o(busy_o), .grant_fetch_o(grant_fetch_o), .grant_dbus_o(grant_dbus_o),
        .grant_pbus_o(grant_pbus_o), .done_o(done_o), .cycles_o(cycles_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One instruction: starts at the current falling edge; expected grant
    // vectors {pbus,dbus,fetch} per cycle. poke pulses a refused start.
    task automatic run_case(input string req, input logic fn, input logic [BW-1:0] fb,
                            input logic dn, input logic [BW-1:0] db,
                            input logic pn, input logic [BW-1:0] pb,
                            input int ncyc, input logic [2:0] e0, input logic [2:0] e1,
                            input logic [2:0] e2, input bit poke);
        logic [2:0] exp_g;
        start_i = 1'b1;
        fetch_need_i = fn; fetch_bank_i = fb;
        dbus_need_i = dn;  dbus_bank_i = db;
        pbus_need_i = pn;  pbus_bank_i = pb;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            if (poke && k == 0) begin
                start_i = 1'b1;
                fetch_need_i = 1'b0; dbus_need_i = 1'b1; pbus_need_i = 1'b0;
            end else begin
                start_i = 1'b0;
                fetch_need_i = ~fn; dbus_need_i = ~dn; pbus_need_i = ~pn;
            end
            exp_g = (k == 0) ? e0 : (k == 1) ? e1 : e2;
            check({req, " busy"}, int'(busy_o), 1);
            check({req, " grants"}, int'({grant_pbus_o, grant_dbus_o, grant_fetch_o}), int'(exp_g));
            check({req, " done"}, int'(done_o), (k == ncyc - 1) ? 1 : 0);
            check({req, " cycles"}, int'(cycles_o), ncyc);
        end
        @(negedge clk);
        start_i = 1'b0;
        check({req, " R9 idle busy"}, int'(busy_o), 0);
        check({req, " R9 idle done"}, int'(done_o), 0);
        check({req, " R2 cycles held"}, int'(cycles_o), ncyc);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 busy", int'(busy_o), 0);
        check("R1 grants", int'({grant_pbus_o, grant_dbus_o, grant_fetch_o}), 0);
        check("R1 done", int'(done_o), 0);
        check("R1 cycles", int'(cycles_o), 0);
        @(negedge clk);
        run_case("R3 all distinct", 1, 2'd0, 1, 2'd1, 1, 2'd2, 1, 3'b111, 3'b000, 3'b000, 0);
        run_case("R4 hit split", 0, 2'd1, 1, 2'd1, 1, 2'd2, 1, 3'b110, 3'b000, 3'b000, 0);
        run_case("R5 R7 data-data", 0, 2'd1, 1, 2'd1, 1, 2'd1, 2, 3'b010, 3'b100, 3'b000, 0);
        run_case("R5 R7 fetch-data", 1, 2'd0, 1, 2'd0, 1, 2'd3, 2, 3'b101, 3'b010, 3'b000, 0);
        run_case("R6 R7 R10 all same", 1, 2'd2, 1, 2'd2, 1, 2'd2, 3, 3'b001, 3'b010, 3'b100, 1);
        run_case("R11 empty", 0, 2'd0, 0, 2'd0, 0, 2'd0, 1, 3'b000, 3'b000, 3'b000, 0);
        run_case("R12 one data clash", 1, 2'd1, 1, 2'd1, 0, 2'd1, 2, 3'b001, 3'b010, 3'b000, 0);
        run_case("R12 one data free", 1, 2'd0, 1, 2'd3, 0, 2'd0, 1, 3'b011, 3'b000, 3'b000, 0);
        run_case("R12 R8 pbus clash", 1, 2'd2, 0, 2'd2, 1, 2'd2, 2, 3'b001, 3'b100, 3'b000, 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule